// File: doc/BRIEF.md
# Dual-Mode Traffic Signal Sequencer

This block is a synchronous Moore machine that drives three lamp outputs (red, yellow, green) in one of two operating modes. In day mode it steps through a four-phase signal cycle. In night mode it flashes the yellow lamp by alternating between yellow and dark. The machine moves only on clock edges where a step tick is high, so an outside timer sets how long each phase lasts. The mode request input is sampled on those same ticks. A high request moves the machine into the other mode, and it always enters that mode through the mode's yellow phase.

The state is held in three JK flip-flops. Minimised J/K excitation equations for each flip-flop are computed from the present state bits and the mode request. The two unused codes fall back to red, and they show every lamp off while they are held, so a corrupted state clears itself on the next tick.

Top module: `tlc_dual_mode`

## Requirements
- R1: A synchronous reset puts the machine in the red phase (state code 000). After reset the lamps read red=1, yellow=0, green=0.
- R2: On a clock edge where `step` is low, the state and the lamps do not change, whatever `mode_req` is.
- R3: In day mode, on each tick with `mode_req`=0 the machine moves red (000) → red+yellow (001) → green (010) → day yellow (011) → red, and then repeats.
- R4: In night mode, on each tick with `mode_req`=0 the machine alternates between night yellow (100) and dark (101).
- R5: On a tick with `mode_req`=1 in any day phase (000 to 011), the next state is night yellow (100).
- R6: On a tick with `mode_req`=1 in either night phase (100, 101), the next state is day yellow (011). The next tick with `mode_req`=0 then leads to red.
- R7: The lamps depend only on the state, written {red,yellow,green}: 000→100, 001→110, 010→001, 011→010, 100→010, 101→000, and unused codes →000.
- R8: The green lamp is never lit while red or yellow is lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance tick; the state may change only when it is high |
| mode_req | input | 1 | Mode change request, sampled on ticks |
| lamp_red | output | 1 | Red lamp drive |
| lamp_yellow | output | 1 | Yellow lamp drive |
| lamp_green | output | 1 | Green lamp drive |

## Verification
The assertions check on every cycle that the state holds without a tick and that each ticked transition lands in the correct state. This covers both mode switches and the steps of both cycles. They also check that the yellow lamp is lit only in the three yellow-bearing phases and that green never lights together with another lamp. Only the bench's scenarios can show behaviour seen purely at the lamps: that two yellow states which look identical lead to different futures, that a full cycle comes back to red, and that a long mixed stream of ticks and requests tracks an arithmetic reference model step by step.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
   localparam int unsigned ST_W = 3;

   typedef logic [ST_W-1:0] st_t;

   localparam st_t ST_RED    = 3'b000;
   localparam st_t ST_RED_YL = 3'b001;
   localparam st_t ST_GREEN  = 3'b010;
   localparam st_t ST_DAY_YL = 3'b011;
   localparam st_t ST_NGT_YL = 3'b100;
   localparam st_t ST_DARK   = 3'b101;

   function automatic logic is_day(st_t s);
      return s[2] == 1'b0;
   endfunction

   function automatic logic is_night(st_t s);
      return s[2] & ~s[1];
   endfunction
endpackage

// File: rtl/tlc_jk_bank.sv
module tlc_jk_bank #(
   parameter int unsigned WIDTH = 3,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] j,
   input  logic [WIDTH-1:0] k,
   output logic [WIDTH-1:0] q
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("tlc_jk_bank: WIDTH must be at least 1");
      end
   endgenerate

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic q_r;
      always_ff @(posedge clk) begin
         if (rst)
            q_r <= RST_VAL[b];
         else if (en)
            q_r <= (j[b] & ~q_r) | (~k[b] & q_r);
      end
      assign q[b] = q_r;
   end
endmodule

// File: rtl/tlc_excite.sv
module tlc_excite
   import tlc_pkg::*;
(
   input  st_t  q,
   input  logic mode,
   output st_t  j,
   output st_t  k
);
   logic q2, q1, q0;
   assign {q2, q1, q0} = q;

   always_comb begin
      // bit 2: set when leaving day on request; clear on request or from unused codes
      j[2] = mode;
      k[2] = q1 | mode;
      // bit 1: night request lands on 011; day walk sets it from 001 without request
      j[1] = q2 ? mode : (~mode & q0);
      k[1] = q2 | mode | q0;
      // bit 0
      j[0] = (q2 & ~q1) | (~q2 & ~mode);
      k[0] = ~q2 | q1 | ~mode;
   end
endmodule

// File: rtl/tlc_lamp_dec.sv
module tlc_lamp_dec
   import tlc_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  st_t  st,
   output logic red,
   output logic yellow,
   output logic green
);
   always_comb begin
      red    = ~st[2] & ~st[1];
      yellow = (~st[2] & st[0]) | (st[2] & ~st[1] & ~st[0]);
      green  = ~st[2] & st[1] & ~st[0];
   end

   // R7: yellow only in the three yellow-bearing phases
   a_r7_yellow_phases: assert property (@(posedge clk) disable iff (rst)
      yellow |-> (st == ST_RED_YL || st == ST_DAY_YL || st == ST_NGT_YL));
   // R8: green exclusive
   a_r8_green_alone: assert property (@(posedge clk) disable iff (rst)
      green |-> (!red && !yellow));
endmodule

// File: rtl/tlc_dual_mode.sv
module tlc_dual_mode
   import tlc_pkg::*;
#(
   parameter int unsigned STATE_BITS = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic step,
   input  logic mode_req,
   output logic lamp_red,
   output logic lamp_yellow,
   output logic lamp_green
);
   generate
      if (STATE_BITS != ST_W) begin : g_bad_bits
         $error("tlc_dual_mode: STATE_BITS must equal the package state width");
      end
   endgenerate

   st_t state_q, j_vec, k_vec;

   tlc_excite u_excite (
      .q    (state_q),
      .mode (mode_req),
      .j    (j_vec),
      .k    (k_vec)
   );

   tlc_jk_bank #(.WIDTH(ST_W), .RST_VAL(ST_RED)) u_regs (
      .clk (clk),
      .rst (rst),
      .en  (step),
      .j   (j_vec),
      .k   (k_vec),
      .q   (state_q)
   );

   tlc_lamp_dec u_dec (
      .clk    (clk),
      .rst    (rst),
      .st     (state_q),
      .red    (lamp_red),
      .yellow (lamp_yellow),
      .green  (lamp_green)
   );

   // R2: no tick, no movement
   a_r2_hold: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(state_q));
   // R3: day walk
   a_r3_day_walk: assert property (@(posedge clk) disable iff (rst)
      (step && !mode_req && is_day(state_q)) |=>
         (state_q == (($past(state_q) == ST_DAY_YL) ? ST_RED : $past(state_q) + 3'd1)));
   // R4: night flash
   a_r4_night_flash: assert property (@(posedge clk) disable iff (rst)
      (step && !mode_req && is_night(state_q)) |=>
         (state_q[2:1] == 2'b10 && state_q[0] != $past(state_q[0])));
   // R5: day to night yellow
   a_r5_to_night: assert property (@(posedge clk) disable iff (rst)
      (step && mode_req && is_day(state_q)) |=> (state_q == ST_NGT_YL));
   // R6: night to day yellow
   a_r6_to_day: assert property (@(posedge clk) disable iff (rst)
      (step && mode_req && is_night(state_q)) |=> (state_q == ST_DAY_YL));
endmodule

// File: tb/tb_tlc_dual_mode.sv
module tb_tlc_dual_mode;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic step = 1'b0;
   logic mode_req = 1'b0;
   logic lamp_red, lamp_yellow, lamp_green;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   int model = 0;   // bench reference state code

   always #10 clk = ~clk;   // 50 MHz

   tlc_dual_mode dut (
      .clk         (clk),
      .rst         (rst),
      .step        (step),
      .mode_req    (mode_req),
      .lamp_red    (lamp_red),
      .lamp_yellow (lamp_yellow),
      .lamp_green  (lamp_green)
   );

   function automatic logic [2:0] lamps_of(int s);
      case (s)
         0: return 3'b100;
         1: return 3'b110;
         2: return 3'b001;
         3: return 3'b010;
         4: return 3'b010;
         5: return 3'b000;
         default: return 3'b000;
      endcase
   endfunction

   function automatic int next_of(int s, bit m);
      if (s >= 6) return 0;
      if (s < 4) return m ? 4 : (s + 1) % 4;
      return m ? 3 : (s == 4 ? 5 : 4);
   endfunction

   task automatic check(string tag);
      logic [2:0] got, exp;
      got = {lamp_red, lamp_yellow, lamp_green};
      exp = lamps_of(model);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: state %0d lamps actual %b expected %b", tag, model, got, exp);
      end
   endtask

   // drive at negedge, edge acts, sample at next negedge
   task automatic cyc(bit s, bit m, string tag);
      step = s;
      mode_req = m;
      @(posedge clk);
      if (s) model = next_of(model, m);
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      model = 0;
      check("R1 reset red");

      // R2: no tick with both request levels
      for (int i = 0; i < 4; i++) cyc(1'b0, i[0], "R2 hold");

      // R3: two full day cycles
      for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, "R3 day walk");

      // R5 from every day phase, then R6 from both night phases
      for (int d = 0; d < 4; d++) begin
         rst = 1'b1; @(negedge clk); rst = 1'b0; model = 0;
         check("R1 reset red");
         for (int i = 0; i < d; i++) cyc(1'b1, 1'b0, "R3 day walk");
         cyc(1'b1, 1'b1, "R5 to night yellow");
         cyc(1'b1, 1'b0, "R4 night flash");
         cyc(1'b1, 1'b0, "R4 night flash");
         cyc(1'b0, 1'b1, "R2 hold in night");
         cyc(1'b1, d[0], d[0] ? "R6 from night yellow" : "R4 night flash");
         cyc(1'b1, 1'b1, d[0] ? "R5 to night yellow" : "R6 from dark");
         cyc(1'b1, 1'b0, d[0] ? "R4 night flash" : "R6 then red");
      end

      // long mixed stream against the reference
      for (int i = 0; i < 3000; i++) begin
         bit s, m;
         string tag;
         s = ($urandom_range(0, 3) != 0);
         m = ($urandom_range(0, 4) == 0);
         if (!s) tag = "R2 hold";
         else if (m) tag = (model < 4) ? "R5 to night yellow" : "R6 from night";
         else tag = (model < 4) ? "R3 day walk" : "R4 night flash";
         cyc(s, m, tag);
         n_chk++;
         if (lamp_green && (lamp_red || lamp_yellow)) begin
            n_bad++;
            $display("FAIL R8: lamps actual %b%b%b expected green alone",
                     lamp_red, lamp_yellow, lamp_green);
         end
         if (lamps_of(model) != {lamp_red, lamp_yellow, lamp_green}) begin
            model = model; // already counted by check
         end
      end

      // mid-run reset returns to red
      cyc(1'b1, 1'b1, "R5 or R6 switch");
      rst = 1'b1; step = 1'b1; @(negedge clk); rst = 1'b0; step = 1'b0; model = 0;
      check("R1 reset mid-run");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule